// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Arbiter

The block collects a bank of peripheral interrupt request lines plus one non-maskable line and offers a small CPU a single vector number at a time. Each maskable line latches into a pending flag. A flag is only offered while its line enable is set. One vector can be promoted to a high level, which may interrupt a running normal-level handler. The non-maskable line sits above every other level.

Normal-level candidates are ordered either statically, where the lowest index wins, or in rotation, where the vector granted last drops to the back of the queue. The CPU side uses a request line with a vector, an acknowledge that takes that vector, a return strobe, and an instruction-retired pulse. After a return, the retired pulse opens the request path again.

Top module: `irq_ctrl_2lvl`

## Requirements
- R1: After reset there are no pending flags, `irq_req_o` is low, `in_service_o` is 0, `gie_o` is 0, no vector is promoted and the static order is selected.
- R2: A high `irq_i[k]` makes flag k pending on the next clock. A pending flag whose `irq_en_i` bit is low is never offered, but it stays pending. A flag clears through `irq_clr_i[k]` or through acknowledge of vector k. When a set and a clear fall in the same cycle, the set wins.
- R3: In static mode (`cfg_rr_i`=0) the lowest enabled pending normal vector is offered.
- R4: In rotating mode (`cfg_rr_i`=1) the search starts one above the last granted normal vector and wraps from NUM_SRC-1 to 0. After reset the search starts at vector 0.
- R5: A grant is a cycle with `irq_ack_i` and `irq_req_o` both high. On a grant the offered flag is cleared. The matching `in_service_o` bit is set: bit0 for normal, bit1 for high, bit2 for non-maskable. `gie_o` is cleared.
- R6: A normal vector is offered only when `gie_o` is 1 and no level is in service. `gie_set_i` sets `gie_o`.
- R7: A configuration write with `cfg_hi_en_i`=1 promotes `cfg_hi_vec_i`. That vector then leaves the normal pool. It is offered ahead of normal vectors when `gie_o` is 1 or when only the normal level is in service. It is not offered while the high or non-maskable level is in service.
- R8: A pulse on `nmi_i` makes the non-maskable request pending. It is offered as vector NUM_SRC, ahead of every other level, regardless of `gie_o` and the line enables. It is not offered while its own level is in service.
- R9: `reti_i` clears the highest set `in_service_o` bit only, and it sets `gie_o`.
- R10: After `reti_i`, `irq_req_o` stays low until a cycle with `insn_done_i` has passed.
- R11: A request that is blocked stays pending and is offered once the block lifts. A flag set again before the return is granted again, so in static mode it starves higher indices.
- R12: Under arbitrary interleavings of all inputs, the offered vector, `gie_o` and `in_service_o` follow the rules above cycle by cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_SRC | Request lines, a high level sets the pending flag |
| irq_en_i | input | NUM_SRC | Per-line enable |
| irq_clr_i | input | NUM_SRC | Write-one-to-clear for the pending flags |
| nmi_i | input | 1 | Non-maskable request |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_hi_en_i | input | 1 | Promote a vector to the high level |
| cfg_hi_vec_i | input | IW | Index of the promoted vector |
| cfg_rr_i | input | 1 | 1 selects rotating order, 0 selects static order |
| gie_set_i | input | 1 | Sets the global enable |
| insn_done_i | input | 1 | The CPU retired one instruction |
| irq_ack_i | input | 1 | The CPU takes the offered vector |
| reti_i | input | 1 | Return-from-handler strobe |
| irq_req_o | output | 1 | A vector is offered |
| irq_vec_o | output | VW | Offered vector; NUM_SRC means non-maskable |
| in_service_o | output | 3 | Levels in service {nmi, high, normal} |
| gie_o | output | 1 | Global enable for normal requests |

## Verification
The bench builds the block with NUM_SRC=6. This puts the non-maskable vector at 6 and makes the rotating search wrap at a count that is not a power of two. The index and vector widths then coincide (3 bits), which exercises the casts between them. With six lines, a rotation can be run past its full length within a handful of grants. Starvation, promotion and three-deep nesting can then be exercised quickly, and random traffic covers many more orderings.

// File: rtl/icu_pkg.sv
package icu_pkg;
  typedef enum logic [1:0] {
    LVL_NORM = 2'd0,
    LVL_HIGH = 2'd1,
    LVL_NMI  = 2'd2
  } lvl_e;

  localparam int unsigned NUM_LVL = 3;
endpackage

// File: rtl/icu_pend.sv
module icu_pend #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] pend_q;

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;

  p_set_wins_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((pend_o & $past(set_i)) == $past(set_i)));

  p_clr_only_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~set_i)) |=> ((pend_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/icu_sel.sv
module icu_sel #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = 3
) (
  input  logic [N-1:0]  req_i,
  input  logic          rr_i,
  input  logic [IW-1:0] last_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  function automatic logic [IW-1:0] lowest(input logic [N-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = IW'(i);
    end
    return r;
  endfunction

  logic [N-1:0] above;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      above[i] = req_i[i] && (IW'(i) > last_i);
    end
    valid_o = |req_i;
    if (rr_i && (|above)) idx_o = lowest(above);
    else                  idx_o = lowest(req_i);
    if (valid_o) begin
      p_sel_hit_r3: assert (req_i[idx_o]);
    end
  end
endmodule

// File: rtl/icu_lvl.sv
module icu_lvl
  import icu_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       grant_i,
  input  lvl_e       grant_lvl_i,
  input  logic       reti_i,
  input  logic       gie_set_i,
  input  logic       insn_done_i,
  output logic [2:0] in_service_o,
  output logic       gie_o,
  output logic       hold_o
);
  logic [2:0] is_q, ret_clr, ent_set;
  logic       gie_q, hold_q;

  always_comb begin
    ret_clr = '0;
    if (reti_i) begin
      if      (is_q[2]) ret_clr = 3'b100;
      else if (is_q[1]) ret_clr = 3'b010;
      else if (is_q[0]) ret_clr = 3'b001;
    end
    ent_set = grant_i ? (3'b001 << grant_lvl_i) : 3'b000;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      is_q   <= '0;
      gie_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      is_q <= (is_q & ~ret_clr) | ent_set;
      if (grant_i)                   gie_q <= 1'b0;
      else if (reti_i || gie_set_i)  gie_q <= 1'b1;
      if (reti_i)           hold_q <= 1'b1;
      else if (insn_done_i) hold_q <= 1'b0;
    end
  end

  assign in_service_o = is_q;
  assign gie_o        = gie_q;
  assign hold_o       = hold_q;

  p_entry_gie_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i |=> !gie_o);

  p_ret_gie_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !grant_i) |=> gie_o);

  p_norm_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_i && grant_lvl_i == LVL_NORM) |-> (in_service_o == 3'b000));

  p_ret_order_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !grant_i && in_service_o[2]) |=>
      (!in_service_o[2] && in_service_o[1:0] == $past(in_service_o[1:0])));
endmodule

// File: rtl/irq_ctrl_2lvl.sv
module irq_ctrl_2lvl
  import icu_pkg::*;
#(
  parameter  int unsigned NUM_SRC = 8,
  localparam int unsigned IW      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int unsigned VW      = $clog2(NUM_SRC + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic [NUM_SRC-1:0] irq_en_i,
  input  logic [NUM_SRC-1:0] irq_clr_i,
  input  logic               nmi_i,
  input  logic               cfg_we_i,
  input  logic               cfg_hi_en_i,
  input  logic [IW-1:0]      cfg_hi_vec_i,
  input  logic               cfg_rr_i,
  input  logic               gie_set_i,
  input  logic               insn_done_i,
  input  logic               irq_ack_i,
  input  logic               reti_i,
  output logic               irq_req_o,
  output logic [VW-1:0]      irq_vec_o,
  output logic [2:0]         in_service_o,
  output logic               gie_o
);
  localparam logic [VW-1:0] NMI_VEC = VW'(NUM_SRC);

  logic               hi_en_q, rr_q;
  logic [IW-1:0]      hi_vec_q, last_q;
  logic [NUM_SRC-1:0] pend, hi_mask, norm_req, ack_clr;
  logic               nmi_pend, nmi_clr;
  logic               sel_valid, hi_live, hold;
  logic [IW-1:0]      sel_idx;
  logic               nmi_ok, hi_ok, norm_ok, grant;
  lvl_e               grant_lvl;
  logic [2:0]         is_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_en_q  <= 1'b0;
      hi_vec_q <= '0;
      rr_q     <= 1'b0;
    end else if (cfg_we_i) begin
      hi_en_q  <= cfg_hi_en_i;
      hi_vec_q <= cfg_hi_vec_i;
      rr_q     <= cfg_rr_i;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      hi_mask[i] = hi_en_q && (hi_vec_q == IW'(i));
    end
  end

  assign norm_req = pend & irq_en_i & ~hi_mask;
  assign hi_live  = |(pend & irq_en_i & hi_mask);

  icu_sel #(.N(NUM_SRC), .IW(IW)) u_sel (
    .req_i   (norm_req),
    .rr_i    (rr_q),
    .last_i  (last_q),
    .valid_o (sel_valid),
    .idx_o   (sel_idx)
  );

  assign nmi_ok  = nmi_pend && !is_w[2] && !hold;
  assign hi_ok   = hi_live && !is_w[2] && !is_w[1] && !hold && (gie_o || is_w[0]);
  assign norm_ok = sel_valid && gie_o && (is_w == 3'b000) && !hold;

  always_comb begin
    irq_req_o = 1'b1;
    irq_vec_o = '0;
    grant_lvl = LVL_NORM;
    if (nmi_ok) begin
      irq_vec_o = NMI_VEC;
      grant_lvl = LVL_NMI;
    end else if (hi_ok) begin
      irq_vec_o = VW'(hi_vec_q);
      grant_lvl = LVL_HIGH;
    end else if (norm_ok) begin
      irq_vec_o = VW'(sel_idx);
    end else begin
      irq_req_o = 1'b0;
    end
  end

  assign grant   = irq_ack_i && irq_req_o;
  assign nmi_clr = grant && (grant_lvl == LVL_NMI);

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      ack_clr[i] = grant && (grant_lvl != LVL_NMI) && (irq_vec_o == VW'(i));
    end
  end

  icu_pend #(.W(NUM_SRC)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (irq_i),
    .clr_i  (irq_clr_i | ack_clr),
    .pend_o (pend)
  );

  icu_pend #(.W(1)) u_nmi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (nmi_i),
    .clr_i  (nmi_clr),
    .pend_o (nmi_pend)
  );

  // rotation anchor: last granted normal vector, so vector 0 leads after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               last_q <= IW'(NUM_SRC - 1);
    else if (grant && grant_lvl == LVL_NORM)   last_q <= irq_vec_o[IW-1:0];
  end

  icu_lvl u_lvl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .grant_i      (grant),
    .grant_lvl_i  (grant_lvl),
    .reti_i       (reti_i),
    .gie_set_i    (gie_set_i),
    .insn_done_i  (insn_done_i),
    .in_service_o (is_w),
    .gie_o        (gie_o),
    .hold_o       (hold)
  );

  assign in_service_o = is_w;

  p_ret_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reti_i |=> !irq_req_o);

  p_ack_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant && grant_lvl != LVL_NMI && !(|(irq_i & ack_clr))) |=>
      !(|(pend & $past(ack_clr))));

  p_nmi_taken_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_clr && !nmi_i) |=> (in_service_o[2] && !nmi_pend));
endmodule

// File: tb/irq_ctrl_2lvl_tb_top.sv
`timescale 1ns/1ps
module irq_ctrl_2lvl_tb_top;
  localparam int N  = 6;
  localparam int IW = 3;
  localparam int VW = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic [N-1:0]  irq, en, clr;
  logic          nmi, cfg_we, cfg_hi_en, cfg_rr, gie_set, insn, ack, reti;
  logic [IW-1:0] cfg_hi_vec;
  logic          req_o, gie_w;
  logic [VW-1:0] vec_o;
  logic [2:0]    is_o;

  irq_ctrl_2lvl #(.NUM_SRC(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .irq_en_i(en), .irq_clr_i(clr),
    .nmi_i(nmi), .cfg_we_i(cfg_we), .cfg_hi_en_i(cfg_hi_en), .cfg_hi_vec_i(cfg_hi_vec),
    .cfg_rr_i(cfg_rr), .gie_set_i(gie_set), .insn_done_i(insn), .irq_ack_i(ack),
    .reti_i(reti), .irq_req_o(req_o), .irq_vec_o(vec_o), .in_service_o(is_o), .gie_o(gie_w)
  );

  // reference state
  logic [N-1:0] m_pend;
  logic         m_nmi, m_gie, m_hold, m_hien, m_rr;
  logic [2:0]   m_is;
  int           m_hiv, m_last;
  int           errs = 0, checks = 0;
  string        tag = "R1";
  bit           done = 0;

  function automatic void expect_out(output logic r, output int v, output int lv);
    logic [N-1:0] pool;
    r = 0; v = 0; lv = 0;
    pool = m_pend & en;
    if (m_hien) pool[m_hiv] = 1'b0;
    if (m_nmi && !m_is[2] && !m_hold) begin
      r = 1; v = N; lv = 2;
    end else if (m_hien && m_pend[m_hiv] && en[m_hiv] && !m_is[2] && !m_is[1] &&
                 !m_hold && (m_gie || m_is[0])) begin
      r = 1; v = m_hiv; lv = 1;
    end else if (m_gie && m_is == 3'b000 && !m_hold && pool != '0) begin
      r = 1;
      if (m_rr) begin
        for (int k = N; k >= 1; k--) if (pool[(m_last + k) % N]) v = (m_last + k) % N;
      end else begin
        for (int k = N - 1; k >= 0; k--) if (pool[k]) v = k;
      end
    end
  endfunction

  function automatic logic exp_req();
    logic r; int v, lv;
    expect_out(r, v, lv);
    return r;
  endfunction

  task automatic model_reset();
    m_pend = '0; m_nmi = 0; m_gie = 0; m_hold = 0; m_hien = 0; m_rr = 0;
    m_is = '0; m_hiv = 0; m_last = N - 1;
  endtask

  task automatic clear_pulses();
    irq = '0; clr = '0; nmi = 0; cfg_we = 0; gie_set = 0; insn = 0; ack = 0; reti = 0;
  endtask

  // inputs are set by the caller at a falling edge
  task automatic step();
    logic r; int v, lv;
    logic [2:0] cm, sm;
    #1;
    expect_out(r, v, lv);
    checks++;
    if (req_o !== r || (r && vec_o !== VW'(v))) begin
      errs++;
      $display("FAIL %s req/vec got %0b/%0d expected %0b/%0d", tag, req_o, vec_o, r, v);
    end
    checks++;
    if (gie_w !== m_gie) begin
      errs++;
      $display("FAIL %s gie got %0b expected %0b", tag, gie_w, m_gie);
    end
    checks++;
    if (is_o !== m_is) begin
      errs++;
      $display("FAIL %s in_service got %03b expected %03b", tag, is_o, m_is);
    end
    // advance reference
    cm = '0; sm = '0;
    if (reti) begin
      if (m_is[2]) cm = 3'b100; else if (m_is[1]) cm = 3'b010; else if (m_is[0]) cm = 3'b001;
    end
    if (ack && r) begin
      sm = 3'b001 << lv;
      if (lv != 2) m_pend[v] = 1'b0;
      else m_nmi = 0;
      if (lv == 0) m_last = v;
    end
    m_pend = (m_pend & ~clr) | irq;
    m_nmi  = m_nmi | nmi;
    m_is   = (m_is & ~cm) | sm;
    if (ack && r) m_gie = 0; else if (reti || gie_set) m_gie = 1;
    if (reti) m_hold = 1; else if (insn) m_hold = 0;
    if (cfg_we) begin m_hien = cfg_hi_en; m_hiv = int'(cfg_hi_vec); m_rr = cfg_rr; end
    @(negedge clk);
    clear_pulses();
  endtask

  task automatic ret_and_resume();
    reti = 1; step();
    insn = 1; step();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    rst_n = 0; en = '1; cfg_hi_en = 0; cfg_hi_vec = '0; cfg_rr = 0;
    clear_pulses();
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1"; step(); step();

    tag = "R6"; irq = 6'b001010; step(); step();
    gie_set = 1; step();
    tag = "R3"; step();
    tag = "R2"; en = 6'b110101; step(); step();
    en = '1; step();
    tag = "R5"; ack = 1; step(); step();
    tag = "R6"; irq = 6'b000001; step(); step();
    tag = "R9"; reti = 1; step();
    tag = "R10"; step(); step(); insn = 1; step(); step();
    tag = "R2"; ack = 1; step();
    irq[3] = 1; clr[3] = 1; step();
    clr[3] = 1; clr[1] = 1; step();
    ret_and_resume(); step();

    tag = "R11";
    clr = '1; step();
    for (int k = 0; k < 4; k++) begin
      irq = 6'b000101; step();
      ack = exp_req(); step();
      irq = 6'b000001; step();
      ret_and_resume();
    end
    clr = '1; step();

    tag = "R4";
    cfg_we = 1; cfg_rr = 1; step();
    for (int k = 0; k < 8; k++) begin
      irq = '1; step();
      ack = exp_req(); step();
      ret_and_resume();
    end
    clr = '1; step();

    tag = "R7";
    cfg_we = 1; cfg_rr = 0; cfg_hi_en = 1; cfg_hi_vec = 3'd4; step();
    irq = 6'b010001; step();
    ack = exp_req(); step();
    irq = 6'b000001; step();
    ack = exp_req(); step();
    irq = 6'b010000; step(); step();
    tag = "R9"; ret_and_resume(); step();
    ret_and_resume(); step();

    tag = "R8";
    clr = '1; step();
    irq = 6'b010000; step();
    ack = exp_req(); step();
    nmi = 1; step();
    ack = exp_req(); step();
    nmi = 1; en = '0; step(); step();
    ret_and_resume();
    ack = exp_req(); step();
    ret_and_resume();
    en = '1; ret_and_resume(); step();

    tag = "R12";
    for (int c = 0; c < 4000; c++) begin
      if ($urandom % 3 == 0) irq = N'($urandom);
      if ($urandom % 40 == 0) en = N'($urandom | 32'h15);
      if ($urandom % 25 == 0) clr = N'($urandom);
      nmi     = ($urandom % 70 == 0);
      gie_set = ($urandom % 15 == 0);
      insn    = ($urandom % 2 == 0);
      if ($urandom % 150 == 0) begin
        cfg_we = 1; cfg_hi_en = $urandom % 2; cfg_rr = $urandom % 2;
        cfg_hi_vec = IW'($urandom % N);
      end
      ack  = exp_req() && ($urandom % 3 == 0);
      reti = !ack && (m_is != 0) && ($urandom % 5 == 0);
      step();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule